// File: doc/BRIEF.md
# Four-Channel Accelerator Register Bank with Atomic Bit Aliases

This block is the memory-mapped control and status file of a four-channel processing accelerator. A simple 32-bit bus (byte address, write strobe, write data, combinational read data) reaches every register through four address aliases. Offset +0x0 replaces the writable bits. Offset +0x4 ORs the data in. Offset +0x8 clears the bits that are ones in the data. Offset +0xC XORs the data in. Because of these aliases, software can change single bits without a read-modify-write. A read at any of the four aliases returns the register value.

Three registers sit in the global area: global control at 0x000, global status at 0x010 and channel control at 0x020. Each channel then has a group of four registers: command pointer, semaphore, status and options. Channel n's group starts at 0x100 + n*0x40. The bank drives the per-channel command pointers, semaphore counts, options, enables and priorities out to the channel engines. It takes back completion pulses, semaphore decrement pulses, error reports and live status. One interrupt line is formed from the per-channel completion flags and their enables. None of the interfaces carries a stream of data, so every pin is a plain level or pulse with no valid/ready handshake. Engine pulses are single-cycle and are never stalled.

Top module: `accel_csr_bank`

## Requirements
- R1: After reset, control reads 0xF000_0000: soft reset bit 31 = 1, clock-gate bit 30 = 1, and capability flags 29 (cipher) and 28 (hash) = 1. Channel control, status flags and every channel register read 0, and `irq` is 0.
- R2: A write at alias offset +0x0 replaces all writable bits of the addressed register with the data.
- R3: A write at alias offset +0x4 ORs the data into the writable bits.
- R4: A write at alias offset +0x8 clears the writable bits that are 1 in the data.
- R5: A write at alias offset +0xC inverts the writable bits that are 1 in the data.
- R6: Read-only and unused bits ignore writes on every alias. Control bits 29:28 always read as the capability flags. Only bits 31, 30, 23, 22 and 3:0 of control are writable. Only bits 16, 11:8 and 3:0 of channel control are writable.
- R7: While control bit 31 is 1, every register except control is held at its reset value, and both bus writes and engine reports to those registers are dropped.
- R8: Channel n's command pointer, semaphore (bits 7:0), status and options sit at 0x100+n*0x40 plus 0x00, 0x10, 0x20 and 0x30. Their values drive `cmd_ptr`, `sema_cnt` and `ch_opt`.
- R9: `irq` is 1 exactly when some status flag bit n (status bits 3:0) is 1 while control bit n is also 1.
- R10: A pulse on `eng_done[n]` sets status flag n. If a bus write to the status register in the same cycle would clear that flag, the flag is still set.
- R11: A pulse on `eng_err_valid[n]` ORs `eng_err_flags` into channel status bits 6:1 and loads `eng_err_code` into bits 23:16. The report wins over a bus clear in the same cycle.
- R12: A pulse on `eng_sema_dec[n]` decrements the semaphore by one, stopping at zero. A bus write to that semaphore in the same cycle takes priority and the decrement is dropped.
- R13: Global status bits 19:16 show `eng_ready`, bits 27:24 show `eng_cur_ch` and bit 28 shows `eng_key_ready`. Writes do not change these fields.
- R14: `ch_en`, `ch_hiprio` and `ch0_irq_merge` follow channel control bits 3:0, 11:8 and 16. `soft_rst`, `clk_gate` and `cfg_en` follow control bits 31, 30 and 23:22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_done | input | NCH | Per-channel completion pulse |
| eng_sema_dec | input | NCH | Per-channel semaphore decrement pulse |
| eng_err_valid | input | NCH | Per-channel error report strobe |
| eng_err_flags | input | NCH*6 | Error flags per channel, channel n at [6n+5:6n] |
| eng_err_code | input | NCH*8 | Error code per channel, channel n at [8n+7:8n] |
| eng_ready | input | NCH | Ready channels (live) |
| eng_cur_ch | input | 4 | Channel currently being served (live) |
| eng_key_ready | input | 1 | Key-ready indication (live) |
| irq | output | 1 | Combined interrupt |
| soft_rst | output | 1 | Control bit 31 |
| clk_gate | output | 1 | Control bit 30 |
| cfg_en | output | 2 | Control bits 23:22 |
| ch_en | output | NCH | Channel enables |
| ch_hiprio | output | NCH | Channel high-priority marks |
| ch0_irq_merge | output | 1 | Channel 0 interrupt merge |
| cmd_ptr | output | NCH*32 | Command pointers, channel n at [32n+31:32n] |
| sema_cnt | output | NCH*8 | Semaphore counts, channel n at [8n+7:8n] |
| ch_opt | output | NCH*32 | Channel option words |

## Verification
Each of the four aliases is applied in turn to a single register from a known value. The bit patterns are chosen so that OR, AND-NOT and XOR give different results, so a swapped or mis-decoded alias changes the value read back. All-ones patterns are written to control and channel control to show which bits are read-only. Every channel group is written with a value unique to that channel, which exposes a wrong stride or a crossed channel index. Engine pulses are applied both alone and in the same cycle as a conflicting bus write, which separates set-wins from bus-wins priority. The interrupt is checked with the flag set and the enable removed, and the reverse.

// File: rtl/accel_csr_pkg.sv
package accel_csr_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TGL   = 2'd3
  } alias_op_e;

  typedef enum logic [1:0] {
    G_NONE   = 2'd0,
    G_CTRL   = 2'd1,
    G_STAT   = 2'd2,
    G_CHCTRL = 2'd3
  } glob_sel_e;

  // order follows address bits [5:4] of the channel group
  typedef enum logic [1:0] {
    CR_PTR  = 2'd0,
    CR_SEMA = 2'd1,
    CR_STAT = 2'd2,
    CR_OPT  = 2'd3
  } chan_reg_e;

  localparam logic [31:0] CH_STAT_MASK = 32'h00FF_007E;
  localparam logic [31:0] SEMA_MASK    = 32'h0000_00FF;

  function automatic logic [31:0] apply_alias(input logic [31:0] cur,
                                              input logic [31:0] data,
                                              input logic [31:0] mask,
                                              input alias_op_e   op);
    logic [31:0] nxt;
    case (op)
      OP_WRITE: nxt = data;
      OP_SET:   nxt = cur | data;
      OP_CLR:   nxt = cur & ~data;
      default:  nxt = cur ^ data;
    endcase
    return (nxt & mask) | (cur & ~mask);
  endfunction

endpackage

// File: rtl/csr_alias_decode.sv
module csr_alias_decode
  import accel_csr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NCH    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output alias_op_e         op,
  output glob_sel_e         glob_sel,
  output logic [NCH-1:0]    ch_hit,
  output chan_reg_e         ch_reg
);

  localparam int HI_W = ADDR_W - 8;

  logic aligned, in_glob, in_chan;

  assign aligned = (addr[1:0] == 2'b00);
  assign in_glob = aligned && (addr[ADDR_W-1:8] == HI_W'(0));
  assign in_chan = aligned && (addr[ADDR_W-1:8] == HI_W'(1));
  assign op      = alias_op_e'(addr[3:2]);
  assign ch_reg  = chan_reg_e'(addr[5:4]);

  always_comb begin
    glob_sel = G_NONE;
    if (in_glob) begin
      case (addr[7:4])
        4'h0:    glob_sel = G_CTRL;
        4'h1:    glob_sel = G_STAT;
        4'h2:    glob_sel = G_CHCTRL;
        default: glob_sel = G_NONE;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign ch_hit[i] = in_chan && (addr[7:6] == 2'(i));
  end

endmodule

// File: rtl/csr_global_regs.sv
module csr_global_regs
  import accel_csr_pkg::*;
#(
  parameter int          NCH        = 4,
  parameter bit          HAS_CIPHER = 1'b1,
  parameter bit          HAS_HASH   = 1'b1,
  parameter logic [31:0] CTRL_RST   = 32'hC000_0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  glob_sel_e      sel,
  input  alias_op_e      op,
  input  logic [31:0]    wdata,
  input  logic [NCH-1:0] eng_done,
  input  logic [NCH-1:0] eng_ready,
  input  logic [3:0]     eng_cur_ch,
  input  logic           eng_key_ready,
  output logic [31:0]    ctrl_rd,
  output logic [31:0]    stat_rd,
  output logic [31:0]    chctrl_rd,
  output logic           hold,
  output logic           irq
);

  localparam logic [31:0] CH_BITS     = 32'((64'd1 << NCH) - 64'd1);
  localparam logic [31:0] CTRL_MASK   = 32'hC0C0_0000 | CH_BITS;
  localparam logic [31:0] STAT_MASK   = CH_BITS;
  localparam logic [31:0] CHCTRL_MASK = 32'h0001_0000 | (CH_BITS << 8) | CH_BITS;
  localparam logic [31:0] CAP_BITS    = {2'b00, HAS_CIPHER, HAS_HASH, 28'h0};

  logic [31:0] ctrl_q, stat_q, chctrl_q;
  logic [31:0] stat_bus, done_w;

  assign hold   = ctrl_q[31];
  assign done_w = 32'(eng_done);

  always_comb begin
    stat_bus = stat_q;
    if (wr && sel == G_STAT) stat_bus = apply_alias(stat_q, wdata, STAT_MASK, op);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST & CTRL_MASK;
      stat_q   <= '0;
      chctrl_q <= '0;
    end else begin
      if (wr && sel == G_CTRL) ctrl_q <= apply_alias(ctrl_q, wdata, CTRL_MASK, op);
      if (hold) begin
        stat_q   <= '0;
        chctrl_q <= '0;
      end else begin
        stat_q <= stat_bus | done_w;
        if (wr && sel == G_CHCTRL)
          chctrl_q <= apply_alias(chctrl_q, wdata, CHCTRL_MASK, op);
      end
    end
  end

  assign ctrl_rd   = ctrl_q | CAP_BITS;
  assign stat_rd   = stat_q | {3'b000, eng_key_ready, eng_cur_ch, 4'h0, 4'(eng_ready), 16'h0};
  assign chctrl_rd = chctrl_q;
  assign irq       = |(stat_q[NCH-1:0] & ctrl_q[NCH-1:0]);

  // R10: a completion pulse always leaves its flag set
  p_done_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && |eng_done) |=> ((stat_q & $past(done_w)) == $past(done_w)));

  // R7: soft reset forces the other registers to reset values
  p_hold_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (chctrl_q == 32'h0 && stat_q == 32'h0));

  // R9: no interrupt without a pending flag
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[NCH-1:0] == '0) |-> !irq);

endmodule

// File: rtl/csr_chan_group.sv
module csr_chan_group
  import accel_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hold,
  input  logic        wr,
  input  chan_reg_e   reg_sel,
  input  alias_op_e   op,
  input  logic [31:0] wdata,
  input  logic        sema_dec,
  input  logic        err_valid,
  input  logic [5:0]  err_flags,
  input  logic [7:0]  err_code,
  output logic [31:0] ptr_q,
  output logic [31:0] sema_q,
  output logic [31:0] stat_q,
  output logic [31:0] opt_q,
  output logic [31:0] rd_val
);

  logic [31:0] stat_bus;
  logic        sema_wr;

  assign sema_wr = wr && reg_sel == CR_SEMA;

  always_comb begin
    stat_bus = stat_q;
    if (wr && reg_sel == CR_STAT) stat_bus = apply_alias(stat_q, wdata, CH_STAT_MASK, op);
    if (err_valid) begin
      stat_bus[6:1]   = stat_bus[6:1] | err_flags;
      stat_bus[23:16] = err_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      sema_q <= '0;
      stat_q <= '0;
      opt_q  <= '0;
    end else if (hold) begin
      ptr_q  <= '0;
      sema_q <= '0;
      stat_q <= '0;
      opt_q  <= '0;
    end else begin
      if (wr && reg_sel == CR_PTR) ptr_q <= apply_alias(ptr_q, wdata, 32'hFFFF_FFFF, op);
      if (wr && reg_sel == CR_OPT) opt_q <= apply_alias(opt_q, wdata, 32'hFFFF_FFFF, op);
      if (sema_wr)
        sema_q <= apply_alias(sema_q, wdata, SEMA_MASK, op);
      else if (sema_dec && sema_q[7:0] != 8'h00)
        sema_q <= sema_q - 32'd1;
      stat_q <= stat_bus;
    end
  end

  always_comb begin
    case (reg_sel)
      CR_PTR:  rd_val = ptr_q;
      CR_SEMA: rd_val = sema_q;
      CR_STAT: rd_val = stat_q;
      default: rd_val = opt_q;
    endcase
  end

  // R12: an engine decrement without a competing bus write lowers the count by one
  p_sema_dec_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && sema_dec && !sema_wr && sema_q[7:0] != 8'h00) |=>
      (sema_q[7:0] == $past(sema_q[7:0]) - 8'd1));

  // R12: the count never wraps below zero
  p_sema_floor_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !sema_wr && sema_q[7:0] == 8'h00) |=> (sema_q[7:0] == 8'h00));

  // R11: an error report is visible in the status register afterwards
  p_err_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && err_valid) |=>
      (((stat_q[6:1] & $past(err_flags)) == $past(err_flags)) &&
       stat_q[23:16] == $past(err_code)));

endmodule

// File: rtl/accel_csr_bank.sv
module accel_csr_bank
  import accel_csr_pkg::*;
#(
  parameter int          ADDR_W     = 10,
  parameter int          NCH        = 4,
  parameter bit          HAS_CIPHER = 1'b1,
  parameter bit          HAS_HASH   = 1'b1,
  parameter logic [31:0] CTRL_RST   = 32'hC000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    eng_done,
  input  logic [NCH-1:0]    eng_sema_dec,
  input  logic [NCH-1:0]    eng_err_valid,
  input  logic [NCH*6-1:0]  eng_err_flags,
  input  logic [NCH*8-1:0]  eng_err_code,
  input  logic [NCH-1:0]    eng_ready,
  input  logic [3:0]        eng_cur_ch,
  input  logic              eng_key_ready,
  output logic              irq,
  output logic              soft_rst,
  output logic              clk_gate,
  output logic [1:0]        cfg_en,
  output logic [NCH-1:0]    ch_en,
  output logic [NCH-1:0]    ch_hiprio,
  output logic              ch0_irq_merge,
  output logic [NCH*32-1:0] cmd_ptr,
  output logic [NCH*8-1:0]  sema_cnt,
  output logic [NCH*32-1:0] ch_opt
);

  alias_op_e      op;
  glob_sel_e      gsel;
  chan_reg_e      creg;
  logic [NCH-1:0] ch_hit;
  logic [31:0]    ctrl_rd, stat_rd, chctrl_rd;
  logic           hold;
  logic [31:0]    rd_ch [NCH];
  logic [31:0]    ptr_v [NCH];
  logic [31:0]    sema_v[NCH];
  logic [31:0]    stat_v[NCH];
  logic [31:0]    opt_v [NCH];

  csr_alias_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
    .addr(bus_addr), .op(op), .glob_sel(gsel), .ch_hit(ch_hit), .ch_reg(creg)
  );

  csr_global_regs #(
    .NCH(NCH), .HAS_CIPHER(HAS_CIPHER), .HAS_HASH(HAS_HASH), .CTRL_RST(CTRL_RST)
  ) u_glob (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(gsel), .op(op), .wdata(bus_wdata),
    .eng_done(eng_done), .eng_ready(eng_ready), .eng_cur_ch(eng_cur_ch),
    .eng_key_ready(eng_key_ready), .ctrl_rd(ctrl_rd), .stat_rd(stat_rd),
    .chctrl_rd(chctrl_rd), .hold(hold), .irq(irq)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    csr_chan_group u_grp (
      .clk(clk), .rst_n(rst_n), .hold(hold),
      .wr(bus_wr && ch_hit[i]), .reg_sel(creg), .op(op), .wdata(bus_wdata),
      .sema_dec(eng_sema_dec[i]), .err_valid(eng_err_valid[i]),
      .err_flags(eng_err_flags[i*6 +: 6]), .err_code(eng_err_code[i*8 +: 8]),
      .ptr_q(ptr_v[i]), .sema_q(sema_v[i]), .stat_q(stat_v[i]), .opt_q(opt_v[i]),
      .rd_val(rd_ch[i])
    );
    assign cmd_ptr[i*32 +: 32] = ptr_v[i];
    assign sema_cnt[i*8 +: 8]  = sema_v[i][7:0];
    assign ch_opt[i*32 +: 32]  = opt_v[i];
  end

  always_comb begin
    case (gsel)
      G_CTRL:   bus_rdata = ctrl_rd;
      G_STAT:   bus_rdata = stat_rd;
      G_CHCTRL: bus_rdata = chctrl_rd;
      default:  bus_rdata = 32'h0;
    endcase
    for (int i = 0; i < NCH; i++)
      if (ch_hit[i]) bus_rdata = bus_rdata | rd_ch[i];
  end

  assign soft_rst      = ctrl_rd[31];
  assign clk_gate      = ctrl_rd[30];
  assign cfg_en        = ctrl_rd[23:22];
  assign ch_en         = chctrl_rd[NCH-1:0];
  assign ch_hiprio     = chctrl_rd[NCH+7:8];
  assign ch0_irq_merge = chctrl_rd[16];

  // R6: capability flags read back unchanged at every control alias
  p_caps_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1:4] == '0 && bus_addr[1:0] == 2'b00) |->
      (bus_rdata[29:28] == {HAS_CIPHER, HAS_HASH}));

  // R7: during soft reset every channel output is idle
  p_hold_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ch_en == '0 && (soft_rst -> cmd_ptr == '0)));

endmodule

// File: tb/accel_csr_bank_test.sv
module accel_csr_bank_test;
  localparam int NCH = 4;
  localparam int AW  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] eng_done = '0, eng_sema_dec = '0, eng_err_valid = '0, eng_ready = '0;
  logic [NCH*6-1:0] eng_err_flags = '0;
  logic [NCH*8-1:0] eng_err_code = '0;
  logic [3:0] eng_cur_ch = '0;
  logic eng_key_ready = 1'b0;
  logic irq, soft_rst, clk_gate, ch0_irq_merge;
  logic [1:0] cfg_en;
  logic [NCH-1:0] ch_en, ch_hiprio;
  logic [NCH*32-1:0] cmd_ptr, ch_opt;
  logic [NCH*8-1:0] sema_cnt;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  accel_csr_bank #(.ADDR_W(AW), .NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done),
    .eng_sema_dec(eng_sema_dec), .eng_err_valid(eng_err_valid),
    .eng_err_flags(eng_err_flags), .eng_err_code(eng_err_code),
    .eng_ready(eng_ready), .eng_cur_ch(eng_cur_ch), .eng_key_ready(eng_key_ready),
    .irq(irq), .soft_rst(soft_rst), .clk_gate(clk_gate), .cfg_en(cfg_en),
    .ch_en(ch_en), .ch_hiprio(ch_hiprio), .ch0_irq_merge(ch0_irq_merge),
    .cmd_ptr(cmd_ptr), .sema_cnt(sema_cnt), .ch_opt(ch_opt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 10'h000, 32'hF000_0000);
    rd_chk("R1 chctrl", 10'h020, 32'h0);
    rd_chk("R1 ch2 ptr", 10'h180, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_soft_hold;
    wr(10'h020, 32'h0000_0003);
    rd_chk("R7 chctrl held", 10'h020, 32'h0);
    wr(10'h008, 32'hC000_0000);
    rd_chk("R4 ctrl clear alias", 10'h000, 32'h3000_0000);
    chk("R14 soft_rst low", 32'(soft_rst), 32'h0);
  endtask

  task automatic t_aliases;
    wr(10'h020, 32'h0000_0103);
    rd_chk("R2 write alias", 10'h020, 32'h0000_0103);
    wr(10'h024, 32'h0000_0800);
    rd_chk("R3 set alias", 10'h020, 32'h0000_0903);
    wr(10'h028, 32'h0000_0001);
    rd_chk("R4 clear alias", 10'h020, 32'h0000_0902);
    wr(10'h02C, 32'h0001_0F0F);
    rd_chk("R5 toggle alias", 10'h02C, 32'h0001_060D);
    wr(10'h020, 32'hFFFF_FFFF);
    rd_chk("R6 chctrl mask", 10'h020, 32'h0001_0F0F);
    chk("R14 ch_en", 32'(ch_en), 32'hF);
    chk("R14 hiprio", 32'(ch_hiprio), 32'hF);
    chk("R14 merge", 32'(ch0_irq_merge), 32'h1);
    wr(10'h004, 32'h3000_0000);
    wr(10'h00C, 32'h3000_0000);
    rd_chk("R6 ctrl caps", 10'h000, 32'h3000_0000);
    wr(10'h000, 32'h00C0_000F);
    rd_chk("R6 ctrl write", 10'h000, 32'h30C0_000F);
    chk("R14 cfg_en", 32'(cfg_en), 32'h3);
    chk("R14 clk_gate", 32'(clk_gate), 32'h0);
  endtask

  task automatic t_channels;
    for (int n = 0; n < NCH; n++) begin
      wr(AW'(10'h100 + n*10'h40), 32'hA000_0000 + 32'(n));
      wr(AW'(10'h130 + n*10'h40), 32'h0000_5500 + 32'(n));
    end
    for (int n = 0; n < NCH; n++) begin
      rd_chk("R8 ptr", AW'(10'h100 + n*10'h40), 32'hA000_0000 + 32'(n));
      rd_chk("R8 opt", AW'(10'h130 + n*10'h40), 32'h0000_5500 + 32'(n));
      chk("R8 cmd_ptr out", cmd_ptr[n*32 +: 32], 32'hA000_0000 + 32'(n));
    end
  endtask

  task automatic t_sema;
    wr(10'h190, 32'hFFFF_FF03);
    rd_chk("R8 sema mask", 10'h190, 32'h0000_0003);
    @(negedge clk); eng_sema_dec[2] = 1'b1;
    @(negedge clk); eng_sema_dec[2] = 1'b0;
    chk("R12 dec", 32'(sema_cnt[2*8 +: 8]), 32'h2);
    @(negedge clk); eng_sema_dec[2] = 1'b1;
    repeat (3) @(negedge clk);
    eng_sema_dec[2] = 1'b0;
    chk("R12 floor", 32'(sema_cnt[2*8 +: 8]), 32'h0);
    @(negedge clk);
    bus_addr = 10'h190; bus_wdata = 32'h5; bus_wr = 1'b1; eng_sema_dec[2] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_sema_dec[2] = 1'b0;
    rd_chk("R12 bus wins", 10'h190, 32'h5);
  endtask

  task automatic t_status_irq;
    eng_ready = 4'hA; eng_cur_ch = 4'h3; eng_key_ready = 1'b1;
    @(negedge clk); eng_done[1] = 1'b1;
    @(negedge clk); eng_done[1] = 1'b0;
    rd_chk("R10 R13 flag", 10'h010, 32'h130A_0002);
    chk("R9 irq on", 32'(irq), 32'h1);
    wr(10'h018, 32'hFFFF_FFFF);
    rd_chk("R13 ro fields", 10'h010, 32'h130A_0000);
    chk("R9 irq off", 32'(irq), 32'h0);
    @(negedge clk);
    bus_addr = 10'h018; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1; eng_done[2] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_done[2] = 1'b0;
    rd_chk("R10 set wins", 10'h010, 32'h130A_0004);
    wr(10'h008, 32'h0000_0004);
    chk("R9 masked", 32'(irq), 32'h0);
    wr(10'h004, 32'h0000_0004);
    chk("R9 unmasked", 32'(irq), 32'h1);
    wr(10'h01C, 32'h0000_0001);
    rd_chk("R5 flag toggle", 10'h010, 32'h130A_0005);
    wr(10'h018, 32'hFFFF_FFFF);
  endtask

  task automatic t_errors;
    @(negedge clk);
    eng_err_valid[3] = 1'b1; eng_err_flags[3*6 +: 6] = 6'b000101; eng_err_code[3*8 +: 8] = 8'h33;
    @(negedge clk); eng_err_valid[3] = 1'b0;
    rd_chk("R11 report", 10'h1E0, 32'h0033_000A);
    wr(10'h1E8, 32'hFFFF_FFFF);
    rd_chk("R11 clear", 10'h1E0, 32'h0);
    @(negedge clk);
    bus_addr = 10'h128; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
    eng_err_valid[0] = 1'b1; eng_err_flags[5:0] = 6'b100000; eng_err_code[7:0] = 8'h07;
    @(negedge clk);
    bus_wr = 1'b0; eng_err_valid[0] = 1'b0;
    rd_chk("R11 set wins", 10'h120, 32'h0007_0040);
  endtask

  task automatic t_soft_again;
    wr(10'h004, 32'h8000_0000);
    rd_chk("R7 ptr reset", 10'h100, 32'h0);
    rd_chk("R7 ctrl", 10'h000, 32'hB0C0_000F);
    wr(10'h130, 32'h0000_1234);
    rd_chk("R7 write dropped", 10'h130, 32'h0);
    chk("R7 ch_en idle", 32'(ch_en), 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_soft_hold();
    t_aliases();
    t_channels();
    t_sema();
    t_status_irq();
    t_errors();
    t_soft_again();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule